// File: doc/BRIEF.md
# Chip-Select Framed Serial Command Loader

This block receives write-only commands for a DAC controller over a three-wire serial link. The three wires are an active-low chip select, a serial clock and a data line. The block runs on its own system clock. It passes all three wires through a synchroniser and finds the edges on the synchronised copies. While chip select is low, each rising edge of the serial clock moves one data bit into a shift register.

A frame is 16 bits long. The first six bits form a command code, most significant bit first. The next ten bits form a data value, also most significant bit first. The frame is accepted when chip select returns high, and only if exactly 16 bits arrived while it was low. When a frame is accepted, the block loads the code and the value into an output register and raises a valid strobe for one system clock cycle.

A frame that is shorter or longer than 16 bits is dropped, and the output register keeps its old contents. The block does not interpret the command code. Every code, including one that puts the DAC into shutdown, is loaded in the same way, so updates still arrive while the analogue side is shut down.

Top module: `spi_cmd_loader`

## Requirements
- R1: While reset is asserted and after it is released, `cmdValid` is low and `cmdCode` and `cmdData` are zero until the first accepted frame.
- R2: A data bit is sampled on each rising edge of `sclk` while `csN` is low. The first bit of a frame ends up in `cmdCode[5]`, the sixth bit in `cmdCode[0]`, the seventh bit in `cmdData[9]` and the sixteenth bit in `cmdData[0]`.
- R3: When `csN` rises after exactly 16 sampled bits, `cmdValid` is high for exactly one system clock cycle. In that same cycle `cmdCode` and `cmdData` show the new frame.
- R4: When `csN` rises after fewer than 16 sampled bits, no strobe is produced and both output fields keep their previous values.
- R5: When `csN` rises after more than 16 sampled bits, no strobe is produced and the outputs keep their previous values. This holds for frames of any length, because the bit count saturates at 17.
- R6: Rising edges of `sclk` while `csN` is high are ignored. They do not add to the bit count of the next frame and do not change its contents.
- R7: `cmdValid` goes high on the third rising edge of `clk` after the rising edge of `csN` is first present at that edge.
- R8: Outside of a strobe cycle, `cmdCode` and `cmdData` hold their values.
- R9: Every command code from 0 to 63 is loaded unchanged. The block does not filter or decode codes, including a shutdown code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low, asynchronous to `clk` |
| sclk | input | 1 | Serial bit clock, asynchronous to `clk` |
| mosi | input | 1 | Serial data in, sampled on rising edges of `sclk` |
| cmdValid | output | 1 | One-cycle strobe when a frame is accepted |
| cmdCode | output | 6 | Command field of the last accepted frame |
| cmdData | output | 10 | Data field of the last accepted frame |

## Verification
The bench drives frames that are one bit short, exactly 16 bits, 17 bits, and 40 bits long. A loader that committed on a bit count, or that let its counter wrap, would produce a strobe for the wrong length or let a 40-bit frame pass as a shifted 16-bit frame. The bench also toggles the serial clock while chip select is high and then sends a frame. A loader that counted those edges would load a value shifted by the number of stray pulses. The bench measures the strobe latency from the rising edge of chip select and checks that the outputs hold between strobes, which catches a strobe that lasts two cycles or a register that follows the shift register.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftBit;  // take one serial bit into the shift register
    logic commit;    // move the shift register into the output register
  } loadCtl_t;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W = 16,
  localparam int CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sCs,
  input  logic             sSclk,
  output loadCtl_t         ctl,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] CountFull = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CountSat  = CNT_W'(FRAME_W + 1);

  logic prevCs;
  logic prevSclk;
  logic csFall;
  logic csRise;
  logic sclkRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs   <= 1'b1;
      prevSclk <= 1'b0;
    end else begin
      prevCs   <= sCs;
      prevSclk <= sSclk;
    end
  end

  assign csFall   = prevCs & ~sCs;
  assign csRise   = ~prevCs & sCs;
  assign sclkRise = sSclk & ~prevSclk;

  always_comb begin
    ctl          = '0;
    ctl.shiftBit = sclkRise & ~sCs;
    ctl.commit   = csRise & (bitCount == CountFull);
  end

  // The count restarts at each frame start and stops at one past a full frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (csFall) begin
      bitCount <= ctl.shiftBit ? CNT_W'(1) : '0;
    end else if (ctl.shiftBit && bitCount != CountSat) begin
      bitCount <= bitCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/spi_cmd_datapath.sv
module spi_cmd_datapath
  import spi_cmd_pkg::*;
#(
  parameter int CMD_W = 6,
  parameter int DAT_W = 10,
  localparam int FRAME_W = CMD_W + DAT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sMosi,
  input  loadCtl_t         ctl,
  output logic             cmdValid,
  output logic [CMD_W-1:0] cmdCode,
  output logic [DAT_W-1:0] cmdData
);

  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.shiftBit) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], sMosi};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCode  <= '0;
      cmdData  <= '0;
      cmdValid <= 1'b0;
    end else begin
      cmdValid <= ctl.commit;
      if (ctl.commit) begin
        cmdCode <= shiftReg[FRAME_W-1 -: CMD_W];
        cmdData <= shiftReg[DAT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/spi_cmd_loader.sv
module spi_cmd_loader
  import spi_cmd_pkg::*;
#(
  parameter int CMD_W = 6,
  parameter int DAT_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             mosi,
  output logic             cmdValid,
  output logic [CMD_W-1:0] cmdCode,
  output logic [DAT_W-1:0] cmdData
);

  localparam int FRAME_W = CMD_W + DAT_W;
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [2:0]       syncOut;
  logic             sCs;
  logic             sSclk;
  logic             sMosi;
  loadCtl_t         ctl;
  logic [CNT_W-1:0] bitCount;

  spi_cmd_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, mosi}), .dout(syncOut)
  );

  assign {sCs, sSclk, sMosi} = syncOut;

  spi_cmd_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sCs(sCs), .sSclk(sSclk),
    .ctl(ctl), .bitCount(bitCount)
  );

  spi_cmd_datapath #(.CMD_W(CMD_W), .DAT_W(DAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .sMosi(sMosi), .ctl(ctl),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdData(cmdData)
  );

endmodule

// File: rtl/spi_cmd_loader_chk.sv
module spi_cmd_loader_chk #(
  parameter int CMD_W = 6,
  parameter int DAT_W = 10,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmdCode,
  input logic [DAT_W-1:0] cmdData,
  input logic [CNT_W-1:0] bitCount,
  input logic             sCs
);

  localparam int FRAME_W = CMD_W + DAT_W;

  // R3: the strobe never lasts two cycles
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R4 and R5: a strobe only follows a full-length count
  p_full_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(bitCount) == CNT_W'(FRAME_W));

  // R5: the counter never passes its saturation value
  p_count_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(FRAME_W + 1));

  // R6: with chip select idle, the count does not move
  p_idle_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    sCs |=> $stable(bitCount));

  // R8: the outputs only change together with a strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> ($stable(cmdCode) && $stable(cmdData)));

endmodule

bind spi_cmd_loader spi_cmd_loader_chk #(
  .CMD_W(CMD_W), .DAT_W(DAT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .cmdData(cmdData), .bitCount(bitCount), .sCs(sCs)
);

// File: tb/tb_spi_cmd_loader.sv
`timescale 1ns/1ps
module tb_spi_cmd_loader;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic cmdValid;
  logic [5:0] cmdCode;
  logic [9:0] cmdData;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_cmd_loader dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdData(cmdData)
  );

  // Reference model: pin history per edge, a bit list and a length counter
  logic [2:0] hist[$];
  bit [15:0] mBits;
  int mLen;
  logic expValid;
  logic [5:0] expCode;
  logic [9:0] expData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = '{3'b100, 3'b100, 3'b100};
      mBits = '0; mLen = 0;
      expValid = 0; expCode = '0; expData = '0;
    end else begin
      logic [2:0] cur, old;
      cur = hist[1]; old = hist[2];
      expValid = 0;
      if (old[2] && !cur[2]) mLen = 0;
      if (!cur[2] && cur[1] && !old[1]) begin
        mBits = {mBits[14:0], cur[0]};
        if (mLen < 17) mLen++;
      end
      if (!old[2] && cur[2] && mLen == 16) begin
        expValid = 1; expCode = mBits[15:10]; expData = mBits[9:0];
      end
      hist.push_front({csN, sclk, mosi});
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (cmdValid) pulses++;
      check(cmdValid === expValid, "R3 strobe", cmdValid, expValid);
      check(cmdCode === expCode, "R2/R8 code", cmdCode, expCode);
      check(cmdData === expData, "R2/R8 data", cmdData, expData);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulseSclk();
    repeat (2) @(negedge clk);
    sclk = 1;
    repeat (3) @(negedge clk);
    sclk = 0;
  endtask

  task automatic sendFrame(input int n, input logic [63:0] val, output int lat);
    csN = 0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = val[i];
      pulseSclk();
    end
    repeat (2) @(negedge clk);
    csN = 1;
    lat = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (cmdValid && lat == 0) lat = i;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int lat;
    int p0;
    repeat (3) @(negedge clk);
    check(cmdValid === 0 && cmdCode === 0 && cmdData === 0, "R1 reset", {cmdValid, cmdCode, cmdData}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(cmdValid === 0 && cmdCode === 0 && cmdData === 0, "R1 after reset", {cmdValid, cmdCode, cmdData}, 0);

    // Exact frame: field split and latency
    sendFrame(16, 64'hA5C3, lat);
    check(cmdCode === 6'h29, "R2 code field", cmdCode, 6'h29);
    check(cmdData === 10'h1C3, "R2 data field", cmdData, 10'h1C3);
    check(lat == 3, "R7 latency", lat, 3);

    // Short frame
    p0 = pulses;
    sendFrame(15, 64'h1234, lat);
    check(pulses == p0, "R4 short no strobe", pulses - p0, 0);
    check(cmdCode === 6'h29 && cmdData === 10'h1C3, "R4 short hold", {cmdCode, cmdData}, 16'hA5C3);

    // 17-bit and 40-bit frames
    p0 = pulses;
    sendFrame(17, 64'h1FFFF, lat);
    check(pulses == p0, "R5 17 bits no strobe", pulses - p0, 0);
    sendFrame(40, 64'hFF_0000_0000 | 64'h0000_5A5A, lat);
    check(pulses == p0, "R5 40 bits no strobe", pulses - p0, 0);
    check(cmdCode === 6'h29 && cmdData === 10'h1C3, "R5 long hold", {cmdCode, cmdData}, 16'hA5C3);

    // Stray clocks with chip select idle, then a frame
    for (int k = 0; k < 5; k++) begin
      mosi = k[0];
      pulseSclk();
    end
    repeat (3) @(negedge clk);
    sendFrame(16, 64'h0F0F, lat);
    check(cmdCode === 6'h03 && cmdData === 10'h30F, "R6 idle edges ignored", {cmdCode, cmdData}, 16'h0F0F);

    // All command codes pass through, including extremes
    for (int c = 0; c < 64; c += 21) begin
      sendFrame(16, {48'h0, c[5:0], 10'h2AA ^ 10'(c)}, lat);
      check(cmdCode === c[5:0], "R9 code passes", cmdCode, c[5:0]);
    end
    sendFrame(16, 64'hFFFF, lat);
    check(cmdCode === 6'h3F && cmdData === 10'h3FF, "R9 all ones", {cmdCode, cmdData}, 16'hFFFF);
    sendFrame(16, 64'h0000, lat);
    check(cmdCode === 0 && cmdData === 0 && lat == 3, "R3 zero frame strobed", {cmdCode, cmdData, 4'(lat)}, 3);

    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule